// File: doc/BRIEF.md
# Cascadable Binary/Decade Up/Down Counter

This block is a chain of identical 4-bit counting stages on one shared clock. Each stage counts up or down. A run-time select chooses between binary counting, where a stage wraps every 16 counts, and decade counting, where it wraps every 10. A single active-low count enable feeds the lowest stage. Each stage passes an active-low carry to the stage above it whenever it is enabled and sits at its terminal value. The whole chain therefore behaves as one wide counter: modulo 16^N in binary mode, or an N-digit BCD counter modulo 10^N in decade mode.

A synchronous load writes a parallel value into every stage in the same cycle and wins over counting. The carry leaving the top stage is meant to serve as a synchronous enable for further logic. It must not be used as a clock.

Top module: `updown_cascade`

## Requirements
- R1: While `rst` is high at a clock edge, every digit of `q` becomes 0 on that edge. Reset takes priority over load and count.
- R2: In binary mode (`binary`=1) each 4-bit digit of `q` counts modulo 16. Counting up from all ones wraps to all zeros.
- R3: In decade mode (`binary`=0) each digit counts 0 to 9 and then returns to 0, so the chain counts modulo 10^STAGES in BCD with digit 0 in `q[3:0]`.
- R4: Counting down (`up`=0), a digit at 0 goes to 15 in binary mode or to 9 in decade mode. Any other digit decrements by one.
- R5: `up` may change between any two cycles, and the count reverses from its present value, for example 9 going to 8 in decade mode.
- R6: When `carry_in_n` is 1 and `load` is 0, `q` holds its value across the clock edge.
- R7: When `load` is 1, `q` takes the value of `jam` on the next edge, whatever the state of `carry_in_n` and `up`.
- R8: `carry_out_n` is 0 exactly when `carry_in_n` is 0 and every digit is at its terminal value. The terminal value is 15 for binary up, 9 for decade up, and 0 for either mode counting down. It is combinational from the present count and inputs.
- R9: A digit above digit 0 advances only on an edge where every digit below it is at its terminal value and `carry_in_n` is 0.
- R10: In decade mode a loaded digit of 10 to 15 goes to 0 on the next enabled up count without producing a carry. Counting down, it decrements by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for all stages |
| rst | input | 1 | Synchronous active-high clear |
| up | input | 1 | 1 counts up, 0 counts down |
| binary | input | 1 | 1 selects modulo-16 digits, 0 selects modulo-10 digits |
| load | input | 1 | Synchronous parallel load of `jam` |
| jam | input | 4*STAGES | Load value, digit 0 in the low nibble |
| carry_in_n | input | 1 | Active-low count enable into digit 0 |
| q | output | 4*STAGES | Present count, digit 0 in the low nibble |
| carry_out_n | output | 1 | Active-low carry from the top digit |

## Verification
The count state is held only in the digit registers, which drive `q` directly. A wrong next-state value therefore appears on `q` one edge after the enabled cycle that produced it.

A fault in the carry chain shows up in two places. It appears on `carry_out_n` in the same cycle, because that output is combinational. It also appears as a wrong upper digit on the first edge where a lower digit wraps.

The bench compares every edge against an integer reference count. Runs reverse direction around both wrap points and insert loads at arbitrary values, so a missed or extra carry is caught within the cycle of the wrap.

// File: rtl/updown_cascade.sv
module updown_cascade #(
  parameter int STAGES = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                up,
  input  logic                binary,
  input  logic                load,
  input  logic [4*STAGES-1:0] jam,
  input  logic                carry_in_n,
  output logic [4*STAGES-1:0] q,
  output logic                carry_out_n
);

  localparam int W = 4 * STAGES;

  logic [STAGES:0] chain_n;
  logic [3:0]      lim;

  assign chain_n[0] = carry_in_n;
  assign lim        = binary ? 4'd15 : 4'd9;

  for (genvar i = 0; i < STAGES; i++) begin : g_digit
    logic [3:0] cnt;
    logic [3:0] nxt;
    logic       en;
    logic       term;

    assign en   = !chain_n[i];
    assign term = up ? (cnt == lim) : (cnt == 4'd0);
    assign chain_n[i+1] = !(en && term);

    always_comb begin
      if (up) nxt = (cnt >= lim) ? 4'd0 : cnt + 4'd1;
      else    nxt = (cnt == 4'd0) ? lim : cnt - 4'd1;
    end

    always_ff @(posedge clk) begin
      if (rst)       cnt <= 4'd0;
      else if (load) cnt <= jam[4*i +: 4];
      else if (en)   cnt <= nxt;
    end

    assign q[4*i +: 4] = cnt;
  end

  assign carry_out_n = chain_n[STAGES];

  logic [W-1:0] unused_w;
  assign unused_w = '0;

endmodule

// File: rtl/updown_cascade_chk.sv
module updown_cascade_chk #(
  parameter int STAGES = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                up,
  input logic                binary,
  input logic                load,
  input logic [4*STAGES-1:0] jam,
  input logic                carry_in_n,
  input logic [4*STAGES-1:0] q,
  input logic                carry_out_n
);

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (q == '0));

  // R7
  load_takes_jam_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(jam)));

  // R6
  hold_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && carry_in_n) |=> $stable(q));

  // R8
  carry_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    !carry_out_n |-> !carry_in_n);

  // R3
  decade_wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !carry_in_n && up && !binary && q[3:0] == 4'd9) |=> (q[3:0] == 4'd0));

  // R4
  wrap_down_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !carry_in_n && !up && q[3:0] == 4'd0)
      |=> (q[3:0] == ($past(binary) ? 4'd15 : 4'd9)));

endmodule

bind updown_cascade updown_cascade_chk #(.STAGES(STAGES)) u_chk (.*);

// File: tb/tb_updown_cascade.sv
module tb_updown_cascade;
  localparam int STAGES = 3;
  localparam int W = 4 * STAGES;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up = 1'b1;
  logic binary = 1'b0;
  logic load = 1'b0;
  logic [W-1:0] jam = '0;
  logic carry_in_n = 1'b1;
  logic [W-1:0] q;
  logic carry_out_n;

  int checks = 0;
  int failures = 0;
  int refv = 0;
  logic [W-1:0] exp_q[$];
  string exp_tag[$];

  always #5 clk = ~clk;

  updown_cascade #(.STAGES(STAGES)) dut (
    .clk(clk), .rst(rst), .up(up), .binary(binary), .load(load),
    .jam(jam), .carry_in_n(carry_in_n), .q(q), .carry_out_n(carry_out_n));

  function automatic int modulus(input logic bin);
    int m = 1;
    for (int d = 0; d < STAGES; d++) m = m * (bin ? 16 : 10);
    return m;
  endfunction

  function automatic logic [W-1:0] enc(input int v, input logic bin);
    logic [W-1:0] r = '0;
    int rest = v;
    for (int d = 0; d < STAGES; d++) begin
      r[4*d +: 4] = 4'(rest % (bin ? 16 : 10));
      rest = rest / (bin ? 16 : 10);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) check(exp_tag.pop_front(), q, exp_q.pop_front());
  end

  task automatic step(input logic u, input logic bin, input logic ld, input int jv,
                      input logic cin, input string tag);
    int m;
    logic exp_co;
    @(negedge clk);
    up = u; load = ld; carry_in_n = cin;
    jam = enc(jv, bin);
    if (bin != binary) begin
      binary = bin;
    end else begin
      #1;
      m = modulus(bin);
      exp_co = !(!cin && (u ? (refv == m - 1) : (refv == 0)));
      check({tag, " R8 carry"}, W'(carry_out_n), W'(exp_co));
    end
    m = modulus(bin);
    if (ld) refv = jv % m;
    else if (!cin) refv = u ? (refv + 1) % m : (refv + m - 1) % m;
    exp_q.push_back(enc(refv, bin));
    exp_tag.push_back(tag);
  endtask

  task automatic raw_step(input logic u, input logic ld, input logic [W-1:0] jr,
                          input logic cin, input logic [W-1:0] e, input string tag);
    @(negedge clk);
    up = u; load = ld; carry_in_n = cin; jam = jr;
    #1;
    if (!ld) check({tag, " R10 no carry"}, W'(carry_out_n), W'(1'b1));
    exp_q.push_back(e);
    exp_tag.push_back(tag);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset", q, '0);
    rst = 1'b0;
    refv = 0;

    step(1, 0, 1, 995, 0, "R7 load");
    for (int k = 0; k < 8; k++) step(1, 0, 0, 0, 0, "R3 R9 decade up");
    for (int k = 0; k < 12; k++) step(0, 0, 0, 0, 0, "R4 R5 decade down");
    for (int k = 0; k < 4; k++) step(1, 0, 0, 0, 0, "R5 reverse up");
    for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 1, "R6 hold");
    step(0, 0, 1, 1, 1, "R7 load while disabled");
    for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, "R4 decade down wrap");

    step(1, 1, 1, 4090, 0, "R7 load binary");
    for (int k = 0; k < 10; k++) step(1, 1, 0, 0, 0, "R2 R9 binary up");
    for (int k = 0; k < 8; k++) step(0, 1, 0, 0, 0, "R4 R5 binary down");
    for (int k = 0; k < 2; k++) step(0, 1, 0, 0, 1, "R6 hold binary");

    for (int k = 0; k < 400; k++) begin
      logic u = 1'($urandom_range(0, 1));
      logic c = ($urandom_range(0, 3) == 0);
      logic l = ($urandom_range(0, 29) == 0);
      step(u, 1, l, int'($urandom_range(0, 4095)), c, "R2 R5 R9 binary mixed");
    end

    step(1, 0, 1, 990, 0, "R7 load decade");
    for (int k = 0; k < 400; k++) begin
      logic u = 1'($urandom_range(0, 1));
      logic c = ($urandom_range(0, 3) == 0);
      logic l = ($urandom_range(0, 29) == 0);
      step(u, 0, l, int'($urandom_range(0, 999)), c, "R3 R5 R9 decade mixed");
    end

    raw_step(1, 1, 12'h00C, 0, 12'h00C, "R10 illegal load");
    raw_step(1, 0, 12'h000, 0, 12'h000, "R10 illegal up");
    raw_step(1, 1, 12'h05F, 0, 12'h05F, "R10 illegal load high");
    raw_step(0, 0, 12'h000, 0, 12'h05E, "R10 illegal down");

    @(negedge clk);
    rst = 1'b1; carry_in_n = 1'b0; load = 1'b1; jam = 12'h123;
    exp_q.push_back('0);
    exp_tag.push_back("R1 reset priority");
    @(negedge clk);
    rst = 1'b0; load = 1'b0; carry_in_n = 1'b1;
    refv = 0;

    repeat (2) @(posedge clk);
    #3;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule